// File: doc/BRIEF.md
# Color Subcarrier Phase Sequencer

This block runs beside the pixel timing of a retro console video core. It tells an NTSC-style composite or S-Video encoder which phase of the color subcarrier belongs to the current pixel. On each clock with the pixel enable high, it moves the beam position one pixel along. Lines and frames wrap at fixed counts, and a single bit records whether the current frame is odd or even. The phase comes out as an index from 0 to 11, where each step is 30 degrees. The index is meant to address a sine table in a later stage. The carrier makes two cycles for every three pixel clocks, so each pixel moves the phase forward by 240 degrees (eight steps).

There are two phase rules, chosen by a mode input.

- **Native mode** keeps the running phase as it is. On odd frames it removes one pixel from one chosen scanline. The following lines then start 240 degrees away from where they would otherwise start.
- **Alternating mode** keeps every line at full length. It adds 180 degrees to the running phase on selected lines, and the pattern swaps between odd and even frames.

A new mode value is only taken when a frame begins, so no frame ever mixes the two rules.

Top module: `chroma_phase_seq`

## Requirements
- R1: While reset is held, and after it is released with no pixel enable, the outputs read phase 0, beam x 0, beam y 0 and frame_odd 0. The active mode is native (mode_alt = 0 selects native, 1 selects alternating).
- R2: A clock with pix_en low changes none of the outputs.
- R3: In native mode, each enabled clock adds 8 to the phase index, modulo 12.
- R4: beam_x counts from 0 up to LINE_LEN-1 and then returns to 0 while beam_y increments. When beam_y wraps from NUM_LINES-1 to 0, frame_odd toggles.
- R5: In native mode, when frame_odd is 1, line SHORT_LINE ends after LINE_LEN-1 pixels. The enabled clock at beam_x = LINE_LEN-2 moves the beam to x 0 of the next line. When frame_odd is 0, every line is full length.
- R6: In alternating mode, the phase output is the running phase plus 6 (modulo 12) on lines where beam_y bit 0 differs from frame_odd. On all other lines it equals the running phase. The running phase still advances by 8 per enabled clock.
- R7: In alternating mode, line SHORT_LINE is full length even when frame_odd is 1.
- R8: mode_alt is sampled only on the enabled clock that wraps beam_y from the last line to 0. A change at any other time has no effect on the phase or the line lengths until that clock.
- R9: The phase index never exceeds 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel enable; all state advances only when high |
| mode_alt | input | 1 | Requested phase rule: 0 native, 1 alternating |
| phase_idx | output | PW (4) | Subcarrier phase in 30-degree steps, 0..11 |
| beam_x | output | XW (9) | Pixel index within the line |
| beam_y | output | YW (9) | Line index within the frame |
| frame_odd | output | 1 | Frame parity: 1 on odd frames |

## Verification
The bench builds the block with LINE_LEN = 7, NUM_LINES = 5 and SHORT_LINE = 2, so a whole frame takes only 34 or 35 pixels. At that size a few hundred pixels cover repeated frame wraps and the shortened line on odd frames. They also cover a mode request that waits through the rest of its frame, and both parities of the alternating offset. The phase rule keeps the default 12 steps and advance of 8, so the 240-degree rotation at the short line is checked exactly as it would be at full size.

// File: rtl/cph_pkg.sv
package cph_pkg;

  typedef enum logic {
    PH_NATIVE = 1'b0,
    PH_ALT    = 1'b1
  } ph_mode_e;

endpackage

// File: rtl/cph_rst_sync.sv
module cph_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];

endmodule

// File: rtl/cph_beam_counter.sv
module cph_beam_counter
  import cph_pkg::*;
#(
  parameter int LINE_LEN   = 341,
  parameter int NUM_LINES  = 262,
  parameter int SHORT_LINE = 20,
  parameter int XW         = 9,
  parameter int YW         = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          mode_req,
  output logic [XW-1:0] x_q,
  output logic [YW-1:0] y_q,
  output logic          frame_q,
  output ph_mode_e      mode_q
);

  localparam logic [XW-1:0] X_FULL  = XW'(LINE_LEN - 1);
  localparam logic [XW-1:0] X_SHORT = XW'(LINE_LEN - 2);
  localparam logic [YW-1:0] Y_LAST  = YW'(NUM_LINES - 1);
  localparam logic [YW-1:0] Y_SHORT = YW'(SHORT_LINE);

  logic [XW-1:0] x_nx;
  logic [YW-1:0] y_nx;
  logic          frame_nx;
  ph_mode_e      mode_nx;
  logic [XW-1:0] x_last;
  logic          short_now;

  // Only native mode on an odd frame trims the chosen line
  assign short_now = (mode_q == PH_NATIVE) && frame_q && (y_q == Y_SHORT);
  assign x_last    = short_now ? X_SHORT : X_FULL;

  always_comb begin
    x_nx     = x_q;
    y_nx     = y_q;
    frame_nx = frame_q;
    mode_nx  = mode_q;
    if (pix_en) begin
      if (x_q == x_last) begin
        x_nx = '0;
        if (y_q == Y_LAST) begin
          y_nx     = '0;
          frame_nx = ~frame_q;
          mode_nx  = ph_mode_e'(mode_req);
        end else begin
          y_nx = y_q + YW'(1);
        end
      end else begin
        x_nx = x_q + XW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      frame_q <= 1'b0;
      mode_q  <= PH_NATIVE;
    end else if (pix_en) begin
      x_q     <= x_nx;
      y_q     <= y_nx;
      frame_q <= frame_nx;
      mode_q  <= mode_nx;
    end
  end

  p_x_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    x_q <= X_FULL);

  p_y_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    y_q <= Y_LAST);

  p_frame_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && x_q == X_FULL && y_q == Y_LAST) |=> (frame_q != $past(frame_q)) && (y_q == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(x_q) && $stable(y_q) && $stable(frame_q));

  p_short_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && mode_q == PH_NATIVE && frame_q && y_q == Y_SHORT && x_q == X_SHORT)
      |=> (x_q == '0) && (y_q == Y_SHORT + YW'(1)));

  p_full_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && mode_q == PH_ALT && x_q == X_SHORT) |=> (x_q == X_FULL));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (x_q != '0 || y_q != '0) |-> $stable(mode_q));

endmodule

// File: rtl/cph_phase_accum.sv
module cph_phase_accum
  import cph_pkg::*;
#(
  parameter int PH_STEPS = 12,
  parameter int PH_ADV   = 8,
  parameter int PW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          line_odd,
  input  logic          frame_odd,
  input  ph_mode_e      mode_cur,
  output logic [PW-1:0] phase_idx
);

  localparam logic [PW:0] STEPS_W = (PW+1)'(PH_STEPS);
  localparam logic [PW:0] ADV_W   = (PW+1)'(PH_ADV);
  localparam logic [PW:0] HALF_W  = (PW+1)'(PH_STEPS / 2);

  logic [PW-1:0] run_q;
  logic [PW-1:0] run_nx;
  logic [PW:0]   adv_sum;
  logic [PW:0]   out_sum;
  logic          flip;

  always_comb begin
    adv_sum = {1'b0, run_q} + ADV_W;
    if (adv_sum >= STEPS_W) adv_sum = adv_sum - STEPS_W;
    run_nx = pix_en ? adv_sum[PW-1:0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (pix_en) run_q <= run_nx;
  end

  // Half-cycle inversion on lines whose parity differs from the frame's
  assign flip = (mode_cur == PH_ALT) && (line_odd ^ frame_odd);

  always_comb begin
    out_sum = {1'b0, run_q} + (flip ? HALF_W : '0);
    if (out_sum >= STEPS_W) out_sum = out_sum - STEPS_W;
    phase_idx = out_sum[PW-1:0];
  end

  p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_idx) < PH_STEPS);

  p_run_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> ((int'(run_q) + PH_STEPS - int'($past(run_q))) % PH_STEPS) == PH_ADV);

  p_run_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(run_q));

endmodule

// File: rtl/chroma_phase_seq.sv
module chroma_phase_seq
  import cph_pkg::*;
#(
  parameter int LINE_LEN   = 341,
  parameter int NUM_LINES  = 262,
  parameter int SHORT_LINE = 20,
  parameter int PH_STEPS   = 12,
  parameter int PH_ADV     = 8,
  localparam int XW        = $clog2(LINE_LEN),
  localparam int YW        = $clog2(NUM_LINES),
  localparam int PW        = $clog2(PH_STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          mode_alt,
  output logic [PW-1:0] phase_idx,
  output logic [XW-1:0] beam_x,
  output logic [YW-1:0] beam_y,
  output logic          frame_odd
);

  logic     rst_sync_n;
  ph_mode_e mode_cur;

  cph_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cph_beam_counter #(
    .LINE_LEN   (LINE_LEN),
    .NUM_LINES  (NUM_LINES),
    .SHORT_LINE (SHORT_LINE),
    .XW         (XW),
    .YW         (YW)
  ) u_beam (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pix_en   (pix_en),
    .mode_req (mode_alt),
    .x_q      (beam_x),
    .y_q      (beam_y),
    .frame_q  (frame_odd),
    .mode_q   (mode_cur)
  );

  cph_phase_accum #(
    .PH_STEPS (PH_STEPS),
    .PH_ADV   (PH_ADV),
    .PW       (PW)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pix_en    (pix_en),
    .line_odd  (beam_y[0]),
    .frame_odd (frame_odd),
    .mode_cur  (mode_cur),
    .phase_idx (phase_idx)
  );

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (beam_x == '0) && (beam_y == '0) && !frame_odd && (phase_idx == '0));

endmodule

// File: tb/chroma_phase_seq_bench.sv
module chroma_phase_seq_bench;

  localparam int L  = 7;
  localparam int N  = 5;
  localparam int SL = 2;
  localparam int XW = $clog2(L);
  localparam int YW = $clog2(N);

  typedef struct {
    string tag;
    int    ph;
    int    x;
    int    y;
    int    f;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_en = 1'b0;
  logic          mode_alt = 1'b0;
  logic [3:0]    phase_idx;
  logic [XW-1:0] beam_x;
  logic [YW-1:0] beam_y;
  logic          frame_odd;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  int   cyc      = 0;
  bit   finished = 1'b0;

  // bench model of the requirements
  int m_x = 0, m_y = 0, m_f = 0, m_run = 0, m_mode = 0;

  chroma_phase_seq #(
    .LINE_LEN   (L),
    .NUM_LINES  (N),
    .SHORT_LINE (SL)
  ) u_chroma_phase_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .mode_alt  (mode_alt),
    .phase_idx (phase_idx),
    .beam_x    (beam_x),
    .beam_y    (beam_y),
    .frame_odd (frame_odd)
  );

  always #4 clk = ~clk;

  function automatic int exp_phase();
    int p;
    p = m_run;
    if (m_mode == 1 && (((m_y % 2) != 0) != (m_f != 0))) p = (p + 6) % 12;
    return p;
  endfunction

  task automatic step(input logic en, input logic md, input string force_tag);
    exp_t  e;
    string t;
    int    last;
    bit    fwrap;
    @(negedge clk);
    pix_en   = en;
    mode_alt = md;
    last  = (m_mode == 0 && m_f == 1 && m_y == SL) ? L - 2 : L - 1;
    fwrap = en && (m_x == last) && (m_y == N - 1);
    if (!en)                                         t = "R2";
    else if (int'(md) != m_mode && !fwrap)           t = "R8";
    else if (fwrap)                                  t = "R4";
    else if (m_mode == 0 && m_f == 1 && m_y == SL && m_x == L - 2) t = "R5";
    else if (m_mode == 1 && m_f == 1 && m_y == SL && m_x == L - 2) t = "R7";
    else if (m_mode == 1)                            t = "R6";
    else                                             t = "R3";
    if (force_tag != "") t = force_tag;
    if (en) begin
      if (m_x == last) begin
        m_x = 0;
        if (m_y == N - 1) begin
          m_y = 0;
          m_f = 1 - m_f;
          m_mode = int'(md);
        end else m_y = m_y + 1;
      end else m_x = m_x + 1;
      m_run = (m_run + 8) % 12;
    end
    e.tag = t;
    e.ph  = exp_phase();
    e.x   = m_x;
    e.y   = m_y;
    e.f   = m_f;
    q.push_back(e);
  endtask

  // monitor: compares after each active edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_checks++;
      if (int'(phase_idx) != e.ph || int'(beam_x) != e.x ||
          int'(beam_y) != e.y || int'(frame_odd) != e.f) begin
        n_fails++;
        $display("FAIL %s: got ph=%0d x=%0d y=%0d f=%0d exp ph=%0d x=%0d y=%0d f=%0d",
                 e.tag, phase_idx, beam_x, beam_y, frame_odd, e.ph, e.x, e.y, e.f);
      end
      n_checks++;
      if (int'(phase_idx) > 11) begin
        n_fails++;
        $display("FAIL R9: got ph=%0d exp <=11", phase_idx);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      n_fails++;
      $display("FAIL watchdog: got cycle %0d exp done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state held with no pixel enable
    repeat (6) step(1'b0, 1'b0, "R1");
    // native frames, with idle gaps
    for (int i = 0; i < 90; i++) step((i % 9) != 4, 1'b0, "");
    // request alternating mid-frame, then run alternating frames
    for (int i = 0; i < 200; i++) step((i % 11) != 6, 1'b1, "");
    // request native mid-frame, then native again
    for (int i = 0; i < 100; i++) step((i % 13) != 3, 1'b0, "");
    step(1'b0, 1'b0, "");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule